// File: doc/BRIEF.md
# Serial Configuration Shift-Latch Port

This block takes a three-wire serial write: a serial clock, a data line and a load-enable line. It turns that write into a held configuration for a clock fanout stage with four banks of two outputs each. While load-enable is low, the host shifts in a fixed-length frame, most significant bit first. Raising load-enable commits the frame to the configuration register, but only if exactly the right number of bits arrived. Otherwise the old configuration stays in place. A readback line echoes each sampled bit after the following falling serial clock edge, so the host can confirm what the port received.

The committed configuration is presented as decoded fields. These are a raw three-bit divider select and a decoded divide ratio per bank, one enable per output, and two output-type bits. A gate flag follows load-enable, and all output enables are forced low while the gate is low. The serial pins are treated as signals synchronous to a faster system clock, and edges are detected by comparing each sample with the previous one. Electrical timing margins are not modelled, only the order of events.

Top module: `sercfg_port`

## Requirements
- R1: After reset, every output is low. This includes all enables, both type bits, the gate flag and the readback line. Every divider select is 0, so every divide ratio reads 1.
- R2: A bit on `serData` is captured on each rising `serClk` edge seen while `loadEn` is low. Frame bits are numbered 22 down to 1 and sent in that order, so bit 22 goes first.
- R3: When `loadEn` rises, the frame is committed only if exactly 22 bits were captured since the previous rise of `loadEn` or since reset. Any other count (0, 21, 23, ...) leaves the configuration unchanged. The bit count restarts at every rise.
- R4: Each bank's divider select is three consecutive frame bits, lowest code bit first. Bank D uses frame bits 22, 21, 20 as code bits 0, 1, 2. Bank C uses 19..17, bank B uses 16..14 and bank A uses 13..11. In `divSel`, bank A sits at [2:0], B at [5:3], C at [8:6] and D at [11:9].
- R5: Each 4-bit slice of `divRatio` (bank A at [3:0] up to D at [15:12]) decodes that bank's code. Codes 0..5 give ratios 1..6, code 7 gives 8, and the reserved code 6 gives 0.
- R6: Frame bits 3..10 are the output enables, 1 meaning enabled, and appear in `outEnable[7:0]` in this order: A0, A1, B0, B1, C0, C1, D0, D1. Frame bit 3 maps to bit 0.
- R7: Frame bit 1 drives `typeBankA` and frame bit 2 drives `typeBankBcd`. A value of 0 selects the low-swing differential type and 1 selects the emitter-coupled type.
- R8: `toggleOk` equals `loadEn` delayed by one system clock. While `toggleOk` is low, `outEnable` is all zeros.
- R9: `serOut` changes only on a falling `serClk` edge. It then takes the most recently captured data bit.
- R10: Rising `serClk` edges while `loadEn` is high are ignored. They capture no bit and do not count toward the frame.
- R11: The configuration register changes only at a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock, synchronous to clk |
| serData | input | 1 | Serial data, captured on rising serClk |
| loadEn | input | 1 | Load enable: low while shifting, rise commits, high lets outputs run |
| serOut | output | 1 | Readback of the last captured bit, updated on falling serClk |
| divSel | output | 12 | Raw divider select codes, 3 bits per bank |
| divRatio | output | 16 | Decoded divide ratio per bank, 0 for reserved |
| outEnable | output | 8 | Gated per-output enables |
| typeBankA | output | 1 | Output type of bank A |
| typeBankBcd | output | 1 | Output type of banks B, C and D |
| toggleOk | output | 1 | Outputs may toggle (registered loadEn) |

## Verification
The assertions assume the serial pins are already synchronous to `clk`. They also assume each serial clock phase lasts at least one system clock, so no edge is missed, and that `serClk` does not rise in the same cycle `loadEn` rises. The bench drives all serial pins on the falling edge of `clk`, and holds each `serClk` phase for two system clocks. It changes `loadEn` only while `serClk` is low and steady.

// File: rtl/sercfg_pkg.sv
`timescale 1ns/1ps
package sercfg_pkg;

  // Frame layout constants shared by the control and the datapath.
  localparam int BANKS         = 4;
  localparam int SEL_W         = 3;
  localparam int OUTS_PER_BANK = 2;
  localparam int OUTS          = BANKS * OUTS_PER_BANK;
  localparam int TYPE_BITS     = 2;
  localparam int FRAME_BITS    = BANKS * SEL_W + OUTS + TYPE_BITS;

  // Strobes from the control to the datapath, one per cycle.
  typedef struct packed {
    logic shift;     // capture serData into the shift register
    logic readback;  // update the readback bit
    logic commit;    // copy a complete frame into the configuration
    logic gate;      // outputs may toggle
  } strobe_t;

endpackage

// File: rtl/sercfg_ctrl.sv
`timescale 1ns/1ps
module sercfg_ctrl
  import sercfg_pkg::*;
#(
  parameter int FRAME_LEN = FRAME_BITS
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    loadEn,
  output strobe_t strb
);

  localparam int CNT_W = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_LEN + 1);

  logic             sclkQ;
  logic             leQ;
  logic [CNT_W-1:0] bitCnt;
  logic             sclkRise;
  logic             sclkFall;
  logic             leRise;

  assign sclkRise = serClk & ~sclkQ;
  assign sclkFall = ~serClk & sclkQ;
  assign leRise   = loadEn & ~leQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      leQ    <= 1'b0;
      bitCnt <= '0;
    end else begin
      sclkQ <= serClk;
      leQ   <= loadEn;
      if (leRise) begin
        bitCnt <= '0;
      end else if (sclkRise && !loadEn && bitCnt != CNT_OVER) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.shift    = sclkRise & ~loadEn;
    strb.readback = sclkFall;
    strb.commit   = leRise & (bitCnt == CNT_FULL);
    strb.gate     = leQ;
  end

  // R10: with loadEn steadily high, serial clock edges do not count
  assert_le_high_no_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && leQ) |=> $stable(bitCnt));

endmodule

// File: rtl/sercfg_dp.sv
`timescale 1ns/1ps
module sercfg_dp
  import sercfg_pkg::*;
#(
  parameter int NBANK = BANKS,
  parameter int SELW  = SEL_W,
  parameter int OPB   = OUTS_PER_BANK
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serData,
  input  strobe_t                  strb,
  output logic                     serOut,
  output logic [NBANK*SELW-1:0]    divSel,
  output logic [NBANK*4-1:0]       divRatio,
  output logic [NBANK*OPB-1:0]     outEnable,
  output logic                     typeBankA,
  output logic                     typeBankBcd
);

  localparam int NOUT   = NBANK * OPB;
  localparam int FLEN   = NBANK * SELW + NOUT + 2;
  localparam int RW     = 4;
  localparam int NCODES = 2 ** SELW;

  logic [FLEN-1:0] shiftReg;
  logic [FLEN-1:0] cfgReg;
  logic            serOutQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      cfgReg   <= '0;
      serOutQ  <= 1'b0;
    end else begin
      if (strb.shift)    shiftReg <= {shiftReg[FLEN-2:0], serData};
      if (strb.readback) serOutQ  <= shiftReg[0];
      if (strb.commit)   cfgReg   <= shiftReg;
    end
  end

  assign serOut = serOutQ;

  function automatic logic [RW-1:0] decodeRatio(input logic [SELW-1:0] code);
    if (int'(code) < NCODES - 2)       return RW'(int'(code) + 1);
    else if (int'(code) == NCODES - 1) return RW'(NCODES);
    else                               return '0;
  endfunction

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    // frame bit number of this bank's code bit 0; register index is one lower
    localparam int TOPBIT = 2 + NOUT + SELW * (b + 1);
    logic [SELW-1:0] code;
    for (genvar k = 0; k < SELW; k++) begin : g_bit
      assign code[k] = cfgReg[TOPBIT - 1 - k];
    end
    assign divSel[b*SELW +: SELW] = code;
    assign divRatio[b*RW +: RW]   = decodeRatio(code);

    // R5: the decoded ratio never takes the unused value 7 nor exceeds the top code
    assert_ratio_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
      (divRatio[b*RW +: RW] != RW'(7)) && (int'(divRatio[b*RW +: RW]) <= NCODES));
  end

  assign outEnable   = cfgReg[NOUT+1:2] & {NOUT{strb.gate}};
  assign typeBankA   = cfgReg[0];
  assign typeBankBcd = cfgReg[1];

  // R11: configuration holds unless a commit strobe arrives
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(cfgReg));

  // R9: readback only moves on a falling serial clock
  assert_rb_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.readback |=> $stable(serOutQ));

  // R10: no capture while load enable is high
  assert_no_shift_le_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(shiftReg));

endmodule

// File: rtl/sercfg_port.sv
`timescale 1ns/1ps
module sercfg_port
  import sercfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        loadEn,
  output logic        serOut,
  output logic [11:0] divSel,
  output logic [15:0] divRatio,
  output logic [7:0]  outEnable,
  output logic        typeBankA,
  output logic        typeBankBcd,
  output logic        toggleOk
);

  strobe_t strb;

  sercfg_ctrl #(.FRAME_LEN(FRAME_BITS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .loadEn (loadEn),
    .strb   (strb)
  );

  sercfg_dp #(.NBANK(BANKS), .SELW(SEL_W), .OPB(OUTS_PER_BANK)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .serData     (serData),
    .strb        (strb),
    .serOut      (serOut),
    .divSel      (divSel),
    .divRatio    (divRatio),
    .outEnable   (outEnable),
    .typeBankA   (typeBankA),
    .typeBankBcd (typeBankBcd)
  );

  assign toggleOk = strb.gate;

  // R8: a low load enable shuts every output off by the next cycle
  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> (outEnable == 8'h00) && !toggleOk);

endmodule

// File: tb/sim_sercfg_port.sv
`timescale 1ns/1ps
module sim_sercfg_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        loadEn = 1'b0;
  logic        serOut;
  logic [11:0] divSel;
  logic [15:0] divRatio;
  logic [7:0]  outEnable;
  logic        typeBankA;
  logic        typeBankBcd;
  logic        toggleOk;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sercfg_port u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .loadEn(loadEn),
    .serOut(serOut), .divSel(divSel), .divRatio(divRatio), .outEnable(outEnable),
    .typeBankA(typeBankA), .typeBankBcd(typeBankBcd), .toggleOk(toggleOk)
  );

  // ---------------- behavioural reference ----------------
  bit        mBits[$];
  int        mCnt;
  bit        mLast, mMiso, mGate, mPrevSclk, mPrevLe;
  bit [22:1] mCfg;

  always @(posedge clk) begin
    if (!rstN) begin
      mBits.delete(); mCnt = 0; mLast = 0; mMiso = 0; mGate = 0;
      mPrevSclk = 0; mPrevLe = 0; mCfg = '0;
    end else begin
      if (!serClk && mPrevSclk) mMiso = mLast;                 // R9
      if (serClk && !mPrevSclk && !loadEn) begin               // R2, R10
        mLast = serData; mBits.push_back(serData); mCnt++;
      end
      if (loadEn && !mPrevLe) begin                            // R3
        if (mCnt == 22) for (int i = 0; i < 22; i++) mCfg[22-i] = mBits[i];
        mCnt = 0; mBits.delete();
      end
      mGate = loadEn; mPrevSclk = serClk; mPrevLe = loadEn;
    end
  end

  function automatic logic [2:0] expCode(int b);
    int top = 13 + 3*b;
    return {mCfg[top-2], mCfg[top-1], mCfg[top]};
  endfunction

  function automatic logic [3:0] expRatio(logic [2:0] c);
    if (c < 6) return 4'(c + 1);
    if (c == 7) return 4'd8;
    return 4'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [11:0] eSel;
      logic [15:0] eRat;
      logic [7:0]  eOe;
      for (int b = 0; b < 4; b++) begin
        eSel[3*b +: 3] = expCode(b);
        eRat[4*b +: 4] = expRatio(expCode(b));
      end
      for (int i = 0; i < 8; i++) eOe[i] = mCfg[3+i] & mGate;
      chk("R4", divSel, eSel, "divSel");
      chk("R5", divRatio, eRat, "divRatio");
      chk("R6", outEnable, eOe, "outEnable");
      chk("R7", {typeBankBcd, typeBankA}, {mCfg[2], mCfg[1]}, "types");
      chk("R8", toggleOk, mGate, "toggleOk");
      chk("R9", serOut, mMiso, "serOut");
    end
  end

  // ---------------- stimulus ----------------
  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [22:1] w, input int n);
    for (int i = 0; i < n; i++) begin
      serData = w[22 - (i % 22)];
      serClk = 1'b0; waitN(2);
      serClk = 1'b1; waitN(2);
      serClk = 1'b0; waitN(2);
    end
  endtask

  task automatic raiseLe();
    loadEn = 1'b1; waitN(3);
  endtask

  task automatic dropLe();
    loadEn = 1'b0; waitN(2);
  endtask

  task automatic writeFrame(input logic [22:1] w);
    dropLe(); sendBits(w, 22); raiseLe();
  endtask

  task automatic report();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    // R1 reset state
    chk("R1", outEnable, 8'h00, "reset outEnable");
    chk("R1", divRatio, 16'h1111, "reset divRatio");
    chk("R1", {toggleOk, serOut, typeBankA, typeBankBcd}, 4'h0, "reset flags");

    // R2/R4/R5: only bit 22 set -> bank D code 1 -> ratio 2
    writeFrame(22'h200000);
    chk("R4", divSel, 12'h200, "bank D bit0");
    chk("R5", divRatio, 16'h2111, "bank D ratio 2");
    // all ones -> code 7 -> ratio 8, all enabled
    writeFrame('1);
    chk("R5", divRatio, 16'h8888, "code 7 ratio 8");
    chk("R6", outEnable, 8'hFF, "all enabled");
    chk("R7", {typeBankBcd, typeBankA}, 2'b11, "types high");

    // R8: dropping loadEn shuts outputs
    dropLe();
    chk("R8", outEnable, 8'h00, "disabled while loadEn low");
    chk("R8", toggleOk, 1'b0, "toggleOk low");
    // R3: rise with zero bits keeps config
    raiseLe();
    chk("R3", divRatio, 16'h8888, "zero-bit rise keeps config");
    chk("R3", outEnable, 8'hFF, "enables restored");
    // R3: 21 and 23 bits discarded
    dropLe(); sendBits('0, 21); raiseLe();
    chk("R3", divRatio, 16'h8888, "21 bits discarded");
    dropLe(); sendBits('0, 23); raiseLe();
    chk("R3", divRatio, 16'h8888, "23 bits discarded");
    // R10: serial clocks with loadEn high are ignored
    sendBits('0, 22);
    chk("R10", divRatio, 16'h8888, "edges while high ignored");
    dropLe(); raiseLe();
    chk("R10", outEnable, 8'hFF, "no count while high");

    // R6 field positions
    writeFrame(22'h000004);
    chk("R6", outEnable, 8'h01, "bit 3 is A0");
    writeFrame(22'h000200);
    chk("R6", outEnable, 8'h80, "bit 10 is D1");
    // R7
    writeFrame(22'h000001);
    chk("R7", {typeBankBcd, typeBankA}, 2'b01, "bit 1 bank A type");
    writeFrame(22'h000002);
    chk("R7", {typeBankBcd, typeBankA}, 2'b10, "bit 2 bank B-D type");
    // R5 reserved code 6 on bank A: frame bits 12 and 11 set
    writeFrame(22'h000C00);
    chk("R5", divRatio, 16'h1110, "reserved code ratio 0");
    chk("R4", divSel, 12'h006, "bank A code 6");

    // random frames, some short, compared every clock by the reference (R2, R11)
    for (int k = 0; k < 40; k++) begin
      logic [22:1] w;
      int n;
      w = 22'($urandom);
      n = (k % 5 == 4) ? 20 + (k % 3) : 22;
      dropLe(); sendBits(w, n); raiseLe();
      waitN(2);
    end
    dropLe();
    waitN(4);
    report();
  end

endmodule